// File: doc/BRIEF.md
# Register-Mapped SPI Shift Controller

This block is an SPI host that software drives through a small 32-bit register bus. Software loads a transmit word, sets the clock divider, and then writes one command word. That word carries a start bit, a chip-select choice, a terminate flag and a bit count. The block shifts the counted bits out on the serial output, most significant counted bit first, and captures the serial input at the same time. When the last bit has moved, the start bit clears itself, so software can poll it to learn that the shift is complete.

A chip select stays low across a run of commands until a command with the terminate flag ends the transaction. The block therefore supports frames longer than 32 bits. While no transaction is active and no shift is running, a pin-control register sets the level of the clock, the serial output and the three chip-select lines directly. Nothing moves on the wire until the enable register has been set.

Top module: `spi_shift_top`

## Requirements
- R1: After reset the pin-control register (offset 0x08) reads 0x0007_0000, every other register reads 0, all three chip selects are high, and SCK and MOSI are low.
- R2: Bit 0 of offset 0x00 enables the controller. While it is 0, a shift command is ignored: the start bit stays 0, SCK does not toggle, and no chip select goes low.
- R3: Bits 5:0 of offset 0x04 hold the divider d. Each SCK half-period lasts d+1 clocks. After an N-bit command is written, the start bit reads 1 for exactly 2·N·(d+1) clocks.
- R4: A write to offset 0x14 is a command only if bit 31 (start) is set. Bits 30:28 select chip selects 2..0, bit 26 is terminate, and bits 6:0 are the bit count. A count above 32 is treated as 32. A read of 0x14 returns busy in bit 31, the held chip select in bits 30:28 and the terminate flag in bit 26.
- R5: SPI mode 0 is used. SCK idles low, MOSI changes only on a falling SCK edge, and MISO is sampled on the rising edge. The first bit out is bit N-1 of the data-out register (offset 0x10), and the remaining bits follow in descending order.
- R6: After an N-bit shift, the data-in register (offset 0x18) holds the received bits right-aligned, with the last bit in bit 0 and all higher bits 0. It keeps this value until the next shift completes.
- R7: A command with terminate set raises its chip select after the shift. A command with terminate clear leaves its chip select low, with SCK and MOSI low, until a later command terminates.
- R8: A command with count 0 or with no chip-select bit set completes at once. SCK does not toggle and data-in is unchanged. If terminate is set, a held chip select is released.
- R9: If several chip-select bits are set, only the lowest-numbered one is asserted.
- R10: Writes to offsets 0x04, 0x10 and 0x14 are ignored while a shift is running.
- R11: With no shift running and no chip select held, bits 18:16 of offset 0x08 drive chip selects 2..0, bit 8 drives SCK, and bit 0 drives MOSI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte offset of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCsN | output | 3 | Active-low chip selects |

## Verification
Assertions check on every cycle the properties that hold at the ports and between the two modules. During a shift at most one chip select is low. MOSI holds steady while SCK is high. A command is never started while the block is disabled. Data-in and the transmit register do not move during a shift. SCK stays low while a chip select is held between commands. The following can only be shown by the bench's scenarios, with its own serial device model, against values it computes itself: the exact shift length for each divider, bit order and alignment for 8, 16 and 32 bits, count clamping, chip-select priority, the hold and release sequence across commands, and the ignoring of writes during a shift.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int CNT_W    = 7;
  localparam int NUM_CS   = 3;
  localparam int DIV_W    = 6;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PINS   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TXD    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RXD    = 8'h18;

  localparam int CMD_START_BIT = 31;
  localparam int CMD_CS_LSB    = 28;
  localparam int CMD_TERM_BIT  = 26;

  localparam logic [WORD_W-1:0] PINS_RESET = 32'h0007_0000;
  localparam int PIN_MOSI_BIT = 0;
  localparam int PIN_SCK_BIT  = 8;
  localparam int PIN_CS_LSB   = 16;

  typedef struct packed {
    logic load;    // begin a counted shift
    logic skip;    // accepted command that moves no bits
    logic rise;    // SCK rising: sample input
    logic fall;    // SCK falling: advance output
    logic finish;  // last falling edge of the shift
  } shiftStrobes_t;

  function automatic logic [CNT_W-1:0] clampCount(input logic [CNT_W-1:0] raw);
    return (raw > CNT_W'(WORD_W)) ? CNT_W'(WORD_W) : raw;
  endfunction
endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DIVW = DIV_W,
  parameter int CNTW = CNT_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [DIVW-1:0] divider,
  input  logic            cmdWrite,
  input  logic [CNTW-1:0] cmdCount,
  input  logic            cmdHasCs,
  output shiftStrobes_t   strobe,
  output logic            busy,
  output logic            sckHigh
);
  logic [DIVW-1:0] divCnt;
  logic [CNTW-1:0] bitsLeft;
  logic            accept, startShift, halfDone;

  assign accept     = cmdWrite && enable && !busy;
  assign startShift = accept && (cmdCount != '0) && cmdHasCs;
  assign halfDone   = busy && (divCnt == divider);

  always_comb begin
    strobe        = '0;
    strobe.load   = startShift;
    strobe.skip   = accept && !startShift;
    strobe.rise   = halfDone && !sckHigh;
    strobe.fall   = halfDone && sckHigh;
    strobe.finish = halfDone && sckHigh && (bitsLeft == CNTW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sckHigh  <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= '0;
    end else if (startShift) begin
      busy     <= 1'b1;
      sckHigh  <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= clampCount(cmdCount);
    end else if (busy) begin
      if (halfDone) begin
        divCnt  <= '0;
        sckHigh <= !sckHigh;
        if (sckHigh) begin
          bitsLeft <= bitsLeft - CNTW'(1);
          if (bitsLeft == CNTW'(1)) busy <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + DIVW'(1);
      end
    end
  end

  // R2: a command seen while disabled never starts a shift
  a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !enable && !busy) |=> !busy);

  // R4: the remaining bit count never exceeds one word
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= CNTW'(WORD_W));

  // R3: the divider counter never passes the divider while shifting
  a_r3_half_period: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !$past(halfDone) |-> divCnt == $past(divCnt) + DIVW'(1));
endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
#(
  parameter int NCS  = NUM_CS,
  parameter int DIVW = DIV_W,
  parameter int CNTW = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  shiftStrobes_t     strobe,
  input  logic              busy,
  input  logic              sckHigh,
  output logic              enable,
  output logic [DIVW-1:0]   divider,
  output logic              cmdWrite,
  output logic [CNTW-1:0]   cmdCount,
  output logic              cmdHasCs,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NCS-1:0]    spiCsN
);
  localparam int SHW = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] pinReg, txReg, rxReg, txShift, rxShift;
  logic [NCS-1:0]    csSel, csPick;
  logic              termReg, csHeld, cmdTerm;
  logic [NCS-1:0]    cmdCs;
  logic [SHW-1:0]    alignAmt;

  assign cmdWrite = busWrEn && (busAddr == OFS_CMD) && busWrData[CMD_START_BIT];
  assign cmdCs    = busWrData[CMD_CS_LSB +: NCS];
  assign cmdTerm  = busWrData[CMD_TERM_BIT];
  assign cmdCount = busWrData[CNTW-1:0];
  assign cmdHasCs = |cmdCs;
  assign csHeld   = |csSel;
  assign alignAmt = SHW'(WORD_W) - SHW'(clampCount(cmdCount));

  // lowest-numbered requested select wins
  always_comb begin
    csPick = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (cmdCs[i]) csPick = '0;
      if (cmdCs[i]) csPick[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      divider <= '0;
      pinReg  <= PINS_RESET;
      txReg   <= '0;
    end else if (busWrEn) begin
      if (busAddr == OFS_ENABLE)          enable  <= busWrData[0];
      if (busAddr == OFS_PINS)            pinReg  <= busWrData;
      if (busAddr == OFS_CTRL && !busy)   divider <= busWrData[DIVW-1:0];
      if (busAddr == OFS_TXD  && !busy)   txReg   <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxReg   <= '0;
      csSel   <= '0;
      termReg <= 1'b0;
    end else begin
      if (strobe.load) begin
        txShift <= txReg << alignAmt;
        rxShift <= '0;
        csSel   <= csPick;
        termReg <= cmdTerm;
      end
      if (strobe.skip && cmdTerm) begin
        csSel   <= '0;
        termReg <= 1'b1;
      end
      if (strobe.rise) rxShift <= {rxShift[WORD_W-2:0], spiMiso};
      if (strobe.fall) txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (strobe.finish) begin
        rxReg <= rxShift;
        if (termReg) csSel <= '0;
      end
    end
  end

  // pin drive: shifter owns the pins during a shift or a held select
  generate
    for (genvar c = 0; c < NCS; c++) begin : g_cs
      assign spiCsN[c] = csHeld ? !csSel[c] : pinReg[PIN_CS_LSB + c];
    end
  endgenerate
  assign spiSck  = busy ? sckHigh     : (csHeld ? 1'b0 : pinReg[PIN_SCK_BIT]);
  assign spiMosi = busy ? txShift[WORD_W-1] : (csHeld ? 1'b0 : pinReg[PIN_MOSI_BIT]);

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_ENABLE: busRdData[0] = enable;
      OFS_CTRL:   busRdData[DIVW-1:0] = divider;
      OFS_PINS:   busRdData = pinReg;
      OFS_TXD:    busRdData = txReg;
      OFS_CMD: begin
        busRdData[CMD_START_BIT]         = busy;
        busRdData[CMD_CS_LSB +: NCS]     = csSel;
        busRdData[CMD_TERM_BIT]          = termReg;
      end
      OFS_RXD:    busRdData = rxReg;
      default:    busRdData = '0;
    endcase
  end

  // R9: at most one chip select low during a shift
  a_r9_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $onehot0(~spiCsN));

  // R5: MOSI does not move while SCK is high within a shift
  a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && spiSck && $past(spiSck)) |-> $stable(spiMosi));

  // R6: captured data stays put while a shift runs
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rxReg));

  // R10: the transmit word is frozen during a shift
  a_r10_tx_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(txReg) && $stable(divider));

  // R7: a held select keeps SCK low between commands
  a_r7_held_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (csHeld && !busy) |-> !spiSck);
endmodule

// File: rtl/spi_shift_top.sv
module spi_shift_top
  import spi_shift_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic               spiSck,
  output logic               spiMosi,
  input  logic               spiMiso,
  output logic [2:0]         spiCsN
);
  shiftStrobes_t    strobe;
  logic             busy, sckHigh, enable, cmdWrite, cmdHasCs;
  logic [DIV_W-1:0] divider;
  logic [CNT_W-1:0] cmdCount;

  spi_shift_ctrl #(.DIVW(DIV_W), .CNTW(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .divider(divider),
    .cmdWrite(cmdWrite), .cmdCount(cmdCount), .cmdHasCs(cmdHasCs),
    .strobe(strobe), .busy(busy), .sckHigh(sckHigh)
  );

  spi_shift_dp #(.NCS(NUM_CS), .DIVW(DIV_W), .CNTW(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .strobe(strobe),
    .busy(busy), .sckHigh(sckHigh), .enable(enable), .divider(divider),
    .cmdWrite(cmdWrite), .cmdCount(cmdCount), .cmdHasCs(cmdHasCs),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );
endmodule

// File: tb/spi_shift_top_tb.sv
module spi_shift_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        spiSck, spiMosi, spiMiso;
  logic [2:0]  spiCsN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // serial device model
  logic [31:0] devOut = '0;
  logic [31:0] devCap = '0;
  int          devRises = 0;
  assign spiMiso = devOut[31];
  always @(posedge spiSck) if (spiCsN != 3'b111) begin
    devCap   <= {devCap[30:0], spiMosi};
    devRises <= devRises + 1;
  end
  always @(negedge spiSck) if (spiCsN != 3'b111) devOut <= devOut << 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_top dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .spiSck(spiSck),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  // counts negedges with start bit high, starting right after the command write
  task automatic waitDone(output int cycles);
    logic [31:0] v;
    cycles = 0;
    rd(8'h14, v);
    while (v[31] && cycles < 5000) begin
      cycles++;
      @(negedge clk);
      rd(8'h14, v);
    end
  endtask

  function automatic logic [31:0] cmd(input int cs, input bit term, input int n);
    return 32'h8000_0000 | (32'(cs) << 28) | (32'(term) << 26) | 32'(n);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h08, v); check("R1 pinctl reset", v, 32'h0007_0000);
    rd(8'h00, v); check("R1 enable reset", v, 0);
    rd(8'h14, v); check("R1 cmd reset", v, 0);
    rd(8'h18, v); check("R1 rx reset", v, 0);
    check("R1 pins idle", {spiCsN, spiSck, spiMosi}, 32'b11100);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    int r0 = devRises;
    wr(8'h14, cmd(1, 1, 8));
    rd(8'h14, v); check("R2 start ignored when disabled", v[31], 0);
    repeat (20) @(negedge clk);
    check("R2 no sck when disabled", 32'(devRises - r0), 0);
    check("R2 cs high when disabled", spiCsN, 3'b111);
  endtask

  task automatic t_basic8();
    int cyc; logic [31:0] v; int r0;
    wr(8'h04, 0); wr(8'h10, 32'h0000_00A5);
    devOut = 32'h3C00_0000; r0 = devRises;
    wr(8'h14, cmd(1, 1, 8));
    check("R4 cs0 low during shift", spiCsN, 3'b110);
    waitDone(cyc);
    check("R3 8 bit div0 length", cyc, 16);
    check("R5 sck rises 8", 32'(devRises - r0), 8);
    check("R5 mosi byte msb first", devCap[7:0], 8'hA5);
    rd(8'h18, v); check("R6 rx byte", v, 32'h3C);
    check("R7 cs released on terminate", spiCsN, 3'b111);
  endtask

  task automatic t_word32();
    int cyc; logic [31:0] v;
    wr(8'h04, 3); wr(8'h10, 32'h1234_5678);
    devOut = 32'hCAFE_F00D;
    wr(8'h14, cmd(1, 1, 32));
    waitDone(cyc);
    check("R3 32 bit div3 length", cyc, 256);
    check("R5 mosi word", devCap, 32'h1234_5678);
    rd(8'h18, v); check("R6 rx word", v, 32'hCAFE_F00D);
  endtask

  task automatic t_half16();
    int cyc; logic [31:0] v;
    wr(8'h04, 1); wr(8'h10, 32'hFFFF_1234);
    devOut = 32'hBEEF_0000;
    wr(8'h14, cmd(1, 1, 16));
    waitDone(cyc);
    check("R3 16 bit div1 length", cyc, 64);
    check("R5 mosi low half", devCap[15:0], 16'h1234);
    rd(8'h18, v); check("R6 rx right aligned", v, 32'h0000_BEEF);
  endtask

  task automatic t_hold();
    int cyc; logic [31:0] v;
    wr(8'h04, 0); wr(8'h10, 32'h5A);
    wr(8'h14, cmd(4, 0, 8));
    waitDone(cyc);
    check("R7 cs2 held", spiCsN, 3'b011);
    check("R7 sck low while held", spiSck, 0);
    rd(8'h14, v); check("R4 held cs readback", v[30:28], 3'b100);
    wr(8'h10, 32'hC3);
    wr(8'h14, cmd(4, 1, 8));
    waitDone(cyc);
    check("R7 two commands one frame", devCap[15:0], 16'h5AC3);
    check("R7 released after terminate", spiCsN, 3'b111);
  endtask

  task automatic t_priority();
    int cyc;
    wr(8'h14, cmd(6, 1, 8));
    check("R9 lowest select wins", spiCsN, 3'b101);
    waitDone(cyc);
  endtask

  task automatic t_empty();
    logic [31:0] v0, v; int r0; int cyc;
    rd(8'h18, v0); r0 = devRises;
    wr(8'h14, cmd(1, 1, 0));
    rd(8'h14, v); check("R8 zero count done at once", v[31], 0);
    check("R8 zero count no sck", 32'(devRises - r0), 0);
    rd(8'h18, v); check("R8 rx unchanged", v, v0);
    wr(8'h10, 32'h77);
    wr(8'h14, cmd(1, 0, 8));
    waitDone(cyc);
    check("R7 cs0 held", spiCsN, 3'b110);
    r0 = devRises;
    wr(8'h14, cmd(0, 1, 8));
    rd(8'h14, v); check("R8 no-cs done at once", v[31], 0);
    check("R8 no-cs no sck", 32'(devRises - r0), 0);
    check("R8 no-cs terminate releases", spiCsN, 3'b111);
  endtask

  task automatic t_busyWrites();
    int cyc; logic [31:0] v; int r0;
    wr(8'h04, 2); wr(8'h10, 32'h0F0F_0F0F);
    r0 = devRises;
    wr(8'h14, cmd(1, 1, 32));
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h04, 5);
    wr(8'h14, cmd(2, 1, 8));
    waitDone(cyc);
    check("R10 tx write ignored", devCap, 32'h0F0F_0F0F);
    rd(8'h10, v); check("R10 tx readback", v, 32'h0F0F_0F0F);
    rd(8'h04, v); check("R10 ctrl readback", v, 2);
    check("R10 cmd ignored", 32'(devRises - r0), 32);
    check("R10 cs idle", spiCsN, 3'b111);
  endtask

  task automatic t_clamp();
    int cyc; int r0;
    wr(8'h04, 0); wr(8'h10, 32'h8000_0001);
    r0 = devRises;
    wr(8'h14, cmd(1, 1, 40));
    waitDone(cyc);
    check("R4 count clamped rises", 32'(devRises - r0), 32);
    check("R4 count clamped length", cyc, 64);
    check("R5 clamped data", devCap, 32'h8000_0001);
  endtask

  task automatic t_manual();
    wr(8'h08, 32'h0005_0101);
    check("R11 manual pins", {spiCsN, spiSck, spiMosi}, 32'b10111);
    wr(8'h08, 32'h0007_0000);
    check("R11 idle pins", {spiCsN, spiSck, spiMosi}, 32'b11100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    wr(8'h00, 1);
    t_basic8();
    t_word32();
    t_half16();
    t_hold();
    t_priority();
    t_empty();
    t_busyWrites();
    t_clamp();
    t_manual();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule